// File: doc/BRIEF.md
# Completed-Descriptor Done Queue Linker

This block keeps the head of a last-in-first-out chain of finished transfer descriptors. Each time the transfer engine reports that a descriptor has finished, the block asks the memory side to store the present chain head into that descriptor's next-pointer word. Once the memory side acknowledges the write, the finished descriptor becomes the new head. Each newly finished descriptor therefore points at the one that finished before it.

When the scheduler signals a write-back, the block hands the current head out on a one-cycle result strobe, so that it can be stored into the shared communication area. In the same step it empties the chain and sets a sticky write-back-done flag. Host software can read the head but cannot change it. It clears the flag by pulsing a clear input.

Top module: `done_queue_linker`

## Requirements
- R1: After a synchronous reset, `host_head` is zero, `wbd_flag` is low, `cmp_busy` is low, `mw_req` is low and `wb_valid` is low.
- R2: `host_head` shows the head pointer in bits [31:4] and always reads zero in bits [3:0]. Bits [3:0] of `cmp_addr` are disregarded, because descriptors are 16-byte aligned.
- R3: A completion is accepted at a clock edge where `cmp_valid` is high and `cmp_busy` is low. In the next cycle `mw_req` is high, `mw_addr` equals the aligned descriptor address plus 8, and `mw_data` equals the value `host_head` had at acceptance.
- R4: `mw_req`, `mw_addr` and `mw_data` hold steady, and `host_head` does not change, until the edge at which `mw_ack` is high. After that edge, `mw_req` and `cmp_busy` are low and `host_head` equals the aligned descriptor address.
- R5: `cmp_busy` is high from the cycle after acceptance until the acknowledge edge. While it is high, `cmp_valid` and `cmp_addr` have no effect.
- R6: A write-back is taken when `wb_strobe` is high, `cmp_busy` is low, no completion is accepted at the same edge, and the head is non-zero. In the next cycle `wb_valid` is high for exactly one cycle, `wb_data` carries the old head, and `host_head` reads zero.
- R7: A taken write-back sets `wbd_flag`. The flag stays high until an edge with `wbd_clear` high and no write-back taken, which drives it low.
- R8: When a taken write-back and `wbd_clear` fall on the same edge, `wbd_flag` ends up high.
- R9: A `wb_strobe` while the head is zero is ignored. `wb_valid` stays low and `wbd_flag` keeps its value.
- R10: A `wb_strobe` while `cmp_busy` is high, or at an edge where a completion is accepted, is ignored. `wb_valid` stays low and the head keeps its value, so the completion takes priority.
- R11: Successive completions form a LIFO chain. The next-pointer written for each descriptor is the address of the descriptor that completed just before it, or zero for the first after an empty head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Descriptor completion strobe, held until accepted |
| cmp_addr | input | 32 | Address of the completed descriptor |
| cmp_busy | output | 1 | Link in flight; completions stall |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 32 | Address of the descriptor's next-pointer word |
| mw_data | output | 32 | Old head value to be written |
| mw_ack | input | 1 | Memory write acknowledge |
| wb_strobe | input | 1 | Write-back event |
| wb_valid | output | 1 | One-cycle pulse: head presented for storage |
| wb_data | output | 32 | Head value being written back |
| host_head | output | 32 | Read-only head register for the host |
| wbd_flag | output | 1 | Sticky write-back-done status |
| wbd_clear | input | 1 | Write-one-to-clear for `wbd_flag` |

## Verification
Two pairs of functions can land on the same edge. A completion acceptance can coincide with a write-back strobe, and a taken write-back can coincide with a status clear. The bench provokes the first pair by raising `cmp_valid` and `wb_strobe` in the same cycle while the head is non-zero. It then requires that no `wb_valid` pulse appears, that `mw_data` still carries the unchanged head, and that the new head after the acknowledge is the accepted descriptor. The bench provokes the second pair by pulsing `wb_strobe` and `wbd_clear` together while the flag is already set, and requires the flag to read high afterwards. A later clear on its own must then drop the flag.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // State of the descriptor link sequencer
  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_WAIT = 1'b1
  } link_state_e;

endpackage

// File: rtl/dq_link_ctrl.sv
module dq_link_ctrl
  import dq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int RSV_BITS = 4,
  parameter int NEXT_OFS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmp_valid,
  input  logic [ADDR_W-1:0]          cmp_addr,
  input  logic [ADDR_W-RSV_BITS-1:0] head_field,
  input  logic                       mw_ack,
  output logic                       busy,
  output logic                       accept,
  output logic                       link_done,
  output logic [ADDR_W-RSV_BITS-1:0] link_ptr,
  output logic                       mw_req,
  output logic [ADDR_W-1:0]          mw_addr,
  output logic [ADDR_W-1:0]          mw_data
);

  localparam int FW = ADDR_W - RSV_BITS;

  link_state_e    state_q;
  logic [FW-1:0]  ptr_q;
  logic [ADDR_W-1:0] addr_q, data_q;
  logic           unused_low;

  // Descriptors are aligned; the low address bits carry no information
  assign unused_low = ^cmp_addr[RSV_BITS-1:0];

  assign busy      = (state_q == LK_WAIT);
  assign accept    = cmp_valid && (state_q == LK_IDLE);
  assign link_done = (state_q == LK_WAIT) && mw_ack;
  assign link_ptr  = ptr_q;
  assign mw_req    = busy;
  assign mw_addr   = addr_q;
  assign mw_data   = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        LK_IDLE: begin
          if (cmp_valid) begin
            state_q <= LK_WAIT;
            ptr_q   <= cmp_addr[ADDR_W-1:RSV_BITS];
            addr_q  <= {cmp_addr[ADDR_W-1:RSV_BITS], {RSV_BITS{1'b0}}}
                       + ADDR_W'(NEXT_OFS);
            data_q  <= {head_field, {RSV_BITS{1'b0}}};
          end
        end
        LK_WAIT: begin
          if (mw_ack) state_q <= LK_IDLE;
        end
        default: state_q <= LK_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mw_req && !mw_ack |=> mw_req && $stable(mw_addr) && $stable(mw_data)); // R4

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    busy && !mw_ack |=> busy && $stable(link_ptr)); // R5

  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> mw_req && (mw_data == $past({head_field, {RSV_BITS{1'b0}}}))); // R3

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    link_done |=> !mw_req); // R4

endmodule

// File: rtl/dq_head_reg.sv
module dq_head_reg #(
  parameter int ADDR_W   = 32,
  parameter int RSV_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       link_busy,
  input  logic                       accept,
  input  logic                       link_done,
  input  logic [ADDR_W-RSV_BITS-1:0] link_ptr,
  input  logic                       wb_strobe,
  output logic                       wb_take,
  output logic [ADDR_W-RSV_BITS-1:0] head_field,
  output logic                       wb_valid,
  output logic [ADDR_W-1:0]          wb_data
);

  localparam int FW = ADDR_W - RSV_BITS;

  logic [FW-1:0] head_q;

  assign head_field = head_q;
  // A write-back yields to any link in progress or starting now
  assign wb_take = wb_strobe && !link_busy && !accept && (head_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= wb_take;
      if (wb_take) begin
        wb_data <= {head_q, {RSV_BITS{1'b0}}};
        head_q  <= '0;
      end else if (link_done) begin
        head_q  <= link_ptr;
      end
    end
  end

  AST_WB_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (head_q == '0)); // R6

  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_data != '0)); // R9

  AST_HEAD_WAITS_ACK: assert property (@(posedge clk) disable iff (rst)
    link_busy && !link_done |=> $stable(head_q)); // R4

  AST_NO_WB_BUSY: assert property (@(posedge clk) disable iff (rst)
    (link_busy || accept) |=> !wb_valid); // R10

endmodule

// File: rtl/dq_status_flag.sv
module dq_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !clr) || set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> flag); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clr && !set |=> !flag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag); // R7

endmodule

// File: rtl/done_queue_linker.sv
module done_queue_linker #(
  parameter int ADDR_W   = 32,
  parameter int RSV_BITS = 4,
  parameter int NEXT_OFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              cmp_busy,
  output logic              mw_req,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [ADDR_W-1:0] mw_data,
  input  logic              mw_ack,
  input  logic              wb_strobe,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_data,
  output logic [ADDR_W-1:0] host_head,
  output logic              wbd_flag,
  input  logic              wbd_clear
);

  localparam int FW = ADDR_W - RSV_BITS;

  logic          accept, link_done, wb_take;
  logic [FW-1:0] link_ptr, head_field;

  dq_link_ctrl #(
    .ADDR_W(ADDR_W), .RSV_BITS(RSV_BITS), .NEXT_OFS(NEXT_OFS)
  ) u_link (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
    .head_field(head_field), .mw_ack(mw_ack),
    .busy(cmp_busy), .accept(accept), .link_done(link_done),
    .link_ptr(link_ptr),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  dq_head_reg #(
    .ADDR_W(ADDR_W), .RSV_BITS(RSV_BITS)
  ) u_head (
    .clk(clk), .rst(rst),
    .link_busy(cmp_busy), .accept(accept),
    .link_done(link_done), .link_ptr(link_ptr),
    .wb_strobe(wb_strobe), .wb_take(wb_take),
    .head_field(head_field),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  dq_status_flag u_flag (
    .clk(clk), .rst(rst),
    .set(wb_take), .clr(wbd_clear),
    .flag(wbd_flag)
  );

  assign host_head = {head_field, {RSV_BITS{1'b0}}};

  AST_HEAD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    mw_req && mw_ack |=> host_head == $past(mw_addr) - ADDR_W'(NEXT_OFS)); // R4

  AST_WB_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wbd_flag); // R7

endmodule

// File: tb/done_queue_linker_bench.sv
`timescale 1ns/1ps
module done_queue_linker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_addr = '0;
  logic        cmp_busy, mw_req, mw_ack = 1'b0;
  logic [31:0] mw_addr, mw_data;
  logic        wb_strobe = 1'b0, wb_valid;
  logic [31:0] wb_data, host_head;
  logic        wbd_flag, wbd_clear = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_head = '0;

  always #2.5 clk = ~clk;

  done_queue_linker u_done_queue_linker (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_busy(cmp_busy),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
    .wb_strobe(wb_strobe), .wb_valid(wb_valid), .wb_data(wb_data),
    .host_head(host_head), .wbd_flag(wbd_flag), .wbd_clear(wbd_clear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // Accept a completion, wait 'dly' cycles, then acknowledge
  task automatic link_one(input logic [31:0] addr, input int dly);
    logic [31:0] al;
    al = {addr[31:4], 4'h0};
    @(negedge clk);
    cmp_valid = 1'b1;
    cmp_addr  = addr;
    tick();
    chk("R3 mw_req", {31'd0, mw_req}, 32'd1);
    chk("R3 mw_addr", mw_addr, al + 32'd8);
    chk("R11 mw_data old head", mw_data, exp_head);
    chk("R5 busy", {31'd0, cmp_busy}, 32'd1);
    @(negedge clk);
    cmp_valid = 1'b0;
    for (int i = 0; i < dly; i++) begin
      tick();
      chk("R4 req held", {31'd0, mw_req}, 32'd1);
      chk("R4 addr held", mw_addr, al + 32'd8);
      chk("R4 head unchanged", host_head, exp_head);
      @(negedge clk);
    end
    mw_ack = 1'b1;
    tick();
    chk("R4 req dropped", {31'd0, mw_req}, 32'd0);
    chk("R4 busy dropped", {31'd0, cmp_busy}, 32'd0);
    chk("R4 head loaded", host_head, al);
    chk("R2 low bits zero", {28'd0, host_head[3:0]}, 32'd0);
    @(negedge clk);
    mw_ack = 1'b0;
    exp_head = al;
  endtask

  task automatic t_reset;
    tick();
    chk("R1 head", host_head, 32'd0);
    chk("R1 flag", {31'd0, wbd_flag}, 32'd0);
    chk("R1 busy", {31'd0, cmp_busy}, 32'd0);
    chk("R1 req", {31'd0, mw_req}, 32'd0);
    chk("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_writeback(input logic with_clear, input logic exp_taken);
    logic [31:0] old;
    logic        old_flag;
    old = exp_head;
    old_flag = wbd_flag;
    @(negedge clk);
    wb_strobe = 1'b1;
    wbd_clear = with_clear;
    tick();
    if (exp_taken) begin
      chk("R6 wb_valid", {31'd0, wb_valid}, 32'd1);
      chk("R6 wb_data", wb_data, old);
      chk("R6 head cleared", host_head, 32'd0);
      chk(with_clear ? "R8 flag set wins" : "R7 flag set",
          {31'd0, wbd_flag}, 32'd1);
      exp_head = '0;
    end else begin
      chk("R9 no wb_valid", {31'd0, wb_valid}, 32'd0);
      chk("R9 flag kept", {31'd0, wbd_flag}, {31'd0, old_flag & ~with_clear});
    end
    @(negedge clk);
    wb_strobe = 1'b0;
    wbd_clear = 1'b0;
    tick();
    chk("R6 single pulse", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    wbd_clear = 1'b1;
    tick();
    chk("R7 cleared", {31'd0, wbd_flag}, 32'd0);
    @(negedge clk);
    wbd_clear = 1'b0;
  endtask

  task automatic t_busy_ignores;
    @(negedge clk);
    cmp_valid = 1'b1;
    cmp_addr  = 32'h0000_4400;
    tick();
    @(negedge clk);
    cmp_addr  = 32'h0000_9990;
    wb_strobe = 1'b1;
    tick();
    chk("R5 addr ignored", mw_addr, 32'h0000_4408);
    chk("R10 no wb while busy", {31'd0, wb_valid}, 32'd0);
    chk("R10 head kept", host_head, exp_head);
    @(negedge clk);
    cmp_valid = 1'b0;
    wb_strobe = 1'b0;
    mw_ack    = 1'b1;
    tick();
    chk("R5 first addr linked", host_head, 32'h0000_4400);
    @(negedge clk);
    mw_ack = 1'b0;
    exp_head = 32'h0000_4400;
  endtask

  task automatic t_same_cycle;
    logic [31:0] old;
    old = exp_head;
    @(negedge clk);
    cmp_valid = 1'b1;
    cmp_addr  = 32'h0000_7770;
    wb_strobe = 1'b1;
    tick();
    chk("R10 accept wins, no wb", {31'd0, wb_valid}, 32'd0);
    chk("R10 mw_data has head", mw_data, old);
    @(negedge clk);
    cmp_valid = 1'b0;
    wb_strobe = 1'b0;
    mw_ack    = 1'b1;
    tick();
    chk("R10 head new", host_head, 32'h0000_7770);
    @(negedge clk);
    mw_ack = 1'b0;
    exp_head = 32'h0000_7770;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_writeback(1'b0, 1'b0);          // R9 empty head
    link_one(32'h0000_1237, 0);       // R2 low bits dropped
    link_one(32'h0000_2000, 3);       // R11 chain
    link_one(32'hABCD_EF50, 1);
    t_writeback(1'b0, 1'b1);          // R6 R7
    t_writeback(1'b0, 1'b0);          // R9 flag kept set
    t_clear();                        // R7
    t_busy_ignores();                 // R5 R10
    t_same_cycle();                   // R10
    t_writeback(1'b0, 1'b1);
    link_one(32'h0000_0100, 2);
    t_writeback(1'b1, 1'b1);          // R8
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule